// File: doc/BRIEF.md
# GPIO Port Controller with Two-Way Peripheral Multiplexing

This block controls one parallel port of `N` pins (32 by default). Each pin is driven either by the port's own GPIO logic or by one of two on-chip peripheral functions, called A and B. The GPIO logic provides an output latch, an output enable and a pull-up control for every pin. On the input side, each pin goes through a two-flop synchroniser and then an optional glitch filter. The resulting level can be read back and is watched for changes in either direction. Each change latches a per-pin event bit. Events that are enabled in the interrupt mask are ORed into a single interrupt line.

Software reaches the block through a plain strobe interface. `wr_en` or `rd_en` is held high for one cycle together with a 5-bit word address. Every configuration vector has three addresses: one that sets the bits written as 1, one that clears the bits written as 1, and one that reads the vector. Reading the event register returns the latched change events and clears them in the same access. A pin's index in the port is the low five bits of its global number; the bits above select the port, which is done outside this block.

The glitch filter samples the synchronised level once every `FLT_DIV` clock cycles. A filtered pin takes a new level only after two consecutive samples agree on it.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset: ownership vector all ones (every pin GPIO-owned), output enable all zero, pull-up all ones, filter enable zero, interrupt mask zero, event vector zero, output latch zero, and peripheral select zero (A). Consequently `pin_oe`=0, `pin_out`=0, `pin_pu` all ones and `irq`=0.
- R2: Set/clear pairs, each changing only the bits written as 1 (codes in decimal: set, clear, read). Ownership uses 0, 1, 2. Output enable uses 3, 4, 5. Pull-up uses 6, 7, 8. Filter enable uses 9, 10, 11. Interrupt mask uses 12, 13, 14.
- R3: The output latch is set through address 15, cleared through 16 and read at 17. Only the bits written as 1 change.
- R4: A pin whose ownership bit is 1 drives its output latch bit on `pin_out` and its enable bit on `pin_oe`. A pin with ownership 0 forwards peripheral A's output and enable when its select bit is 0, and peripheral B's when the select bit is 1. Writing to address 18 clears the select bits written as 1 (choosing A). Writing to address 19 sets them (choosing B). Address 20 reads the select vector.
- R5: Address 21 returns the synchronised pin levels, whatever each pin's direction or owner. With the filter off, a change on `pin_in` applied just after a clock edge is visible on the third following edge and not on the second.
- R6: Every rising or falling change of a pin's level latches that pin's event bit. The bit stays set until the event register (address 22) is read.
- R7: `irq` is high exactly when some event bit is set whose interrupt mask bit is 1. Masked events stay latched without raising `irq`.
- R8: A read of address 22 returns the event vector and clears it. A change that latches in the same cycle as that read stays set.
- R9: With a pin's filter enabled, a pulse shorter than `FLT_DIV` cycles changes neither the level read at address 21 nor the event bit. A level held for 3*`FLT_DIV`+3 cycles is passed through.
- R10: `pin_pu` follows the pull-up vector for every pin, whether the pin is owned by GPIO or by a peripheral.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Word address |
| wdata | input | N | Write mask/data |
| rdata | output | N | Read data, valid while `rd_en` is high |
| pin_in | input | N | Pin levels from the pads |
| pin_out | output | N | Output value to the pads |
| pin_oe | output | N | Output enable to the pads |
| pin_pu | output | N | Pull-up enable to the pads |
| pa_out | input | N | Peripheral A output values |
| pa_oe | input | N | Peripheral A output enables |
| pb_out | input | N | Peripheral B output values |
| pb_oe | input | N | Peripheral B output enables |
| irq | output | 1 | Combined pin-change interrupt |

## Verification
The assertions assume that `addr` and `wdata` hold known values whenever a strobe is high. They also assume that filter enables are not toggled while the affected pin is changing, because switching a pin between its filtered and raw paths can itself register as a change. The stimulus keeps to this: strobes are raised for single cycles from tasks, and the filter configuration changes only while the pins are quiet. In the random phase, pin changes are applied only after the previous change has settled through the synchroniser.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int ADDR_W = 5;

    typedef enum logic [ADDR_W-1:0] {
        A_OWN_SET  = 5'd0,
        A_OWN_CLR  = 5'd1,
        A_OWN_STAT = 5'd2,
        A_OE_SET   = 5'd3,
        A_OE_CLR   = 5'd4,
        A_OE_STAT  = 5'd5,
        A_PU_SET   = 5'd6,
        A_PU_CLR   = 5'd7,
        A_PU_STAT  = 5'd8,
        A_FLT_SET  = 5'd9,
        A_FLT_CLR  = 5'd10,
        A_FLT_STAT = 5'd11,
        A_IEN_SET  = 5'd12,
        A_IEN_CLR  = 5'd13,
        A_IEN_STAT = 5'd14,
        A_DO_SET   = 5'd15,
        A_DO_CLR   = 5'd16,
        A_DO_STAT  = 5'd17,
        A_SEL_A    = 5'd18,
        A_SEL_B    = 5'd19,
        A_SEL_STAT = 5'd20,
        A_PIN_STAT = 5'd21,
        A_EVT_STAT = 5'd22
    } reg_addr_e;

endpackage

// File: rtl/gpio_input_stage.sv
module gpio_input_stage #(
    parameter int N       = 32,
    parameter int FLT_DIV = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_in,
    input  logic [N-1:0] flt_en,
    output logic [N-1:0] lvl,
    output logic [N-1:0] change
);

    localparam int CNT_W = (FLT_DIV > 1) ? $clog2(FLT_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FLT_DIV - 1);

    typedef struct packed {
        logic [N-1:0]     sync1;
        logic [N-1:0]     sync2;
        logic [N-1:0]     hist;
        logic [N-1:0]     filt;
        logic [N-1:0]     lvl;
        logic [CNT_W-1:0] cnt;
    } in_state_t;

    in_state_t st_d, st_q;
    logic      tick;
    logic [N-1:0] agree;

    always_comb begin
        st_d       = st_q;
        st_d.sync1 = pin_in;
        st_d.sync2 = st_q.sync1;
        tick       = (st_q.cnt == CNT_LAST);
        agree      = ~(st_q.sync2 ^ st_q.hist);
        if (tick) begin
            st_d.cnt  = '0;
            st_d.hist = st_q.sync2;
            // a new filtered level needs two consecutive matching samples
            st_d.filt = (st_q.sync2 & agree) | (st_q.filt & ~agree);
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        st_d.lvl = (flt_en & st_q.filt) | (~flt_en & st_q.sync2);
        change   = st_d.lvl ^ st_q.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl = st_q.lvl;

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
    parameter int N = 32
) (
    input  logic [N-1:0] own,
    input  logic [N-1:0] sel_b,
    input  logic [N-1:0] gp_out,
    input  logic [N-1:0] gp_oe,
    input  logic [N-1:0] pa_out,
    input  logic [N-1:0] pa_oe,
    input  logic [N-1:0] pb_out,
    input  logic [N-1:0] pb_oe,
    output logic [N-1:0] pin_out,
    output logic [N-1:0] pin_oe
);

    for (genvar i = 0; i < N; i++) begin : g_pin
        always_comb begin
            if (own[i]) begin
                pin_out[i] = gp_out[i];
                pin_oe[i]  = gp_oe[i];
            end else if (sel_b[i]) begin
                pin_out[i] = pb_out[i];
                pin_oe[i]  = pb_oe[i];
            end else begin
                pin_out[i] = pa_out[i];
                pin_oe[i]  = pa_oe[i];
            end
        end
    end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int N       = 32,
    parameter int FLT_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N-1:0]      wdata,
    output logic [N-1:0]      rdata,
    input  logic [N-1:0]      pin_in,
    output logic [N-1:0]      pin_out,
    output logic [N-1:0]      pin_oe,
    output logic [N-1:0]      pin_pu,
    input  logic [N-1:0]      pa_out,
    input  logic [N-1:0]      pa_oe,
    input  logic [N-1:0]      pb_out,
    input  logic [N-1:0]      pb_oe,
    output logic              irq
);

    typedef struct packed {
        logic [N-1:0] own;
        logic [N-1:0] oe;
        logic [N-1:0] pu;
        logic [N-1:0] flt;
        logic [N-1:0] ien;
        logic [N-1:0] dout;
        logic [N-1:0] sel;
        logic [N-1:0] evt;
    } ctrl_state_t;

    localparam ctrl_state_t RESET_ST = '{
        own: '1, oe: '0, pu: '1, flt: '0,
        ien: '0, dout: '0, sel: '0, evt: '0
    };

    ctrl_state_t  st_d, st_q;
    logic [N-1:0] pin_lvl;
    logic [N-1:0] pin_change;
    reg_addr_e    a_dec;

    gpio_input_stage #(.N(N), .FLT_DIV(FLT_DIV)) in_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .flt_en (st_q.flt),
        .lvl    (pin_lvl),
        .change (pin_change)
    );

    gpio_pin_mux #(.N(N)) mux_i (
        .own     (st_q.own),
        .sel_b   (st_q.sel),
        .gp_out  (st_q.dout),
        .gp_oe   (st_q.oe),
        .pa_out  (pa_out),
        .pa_oe   (pa_oe),
        .pb_out  (pb_out),
        .pb_oe   (pb_oe),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    always_comb begin
        a_dec = reg_addr_e'(addr);
        st_d  = st_q;
        if (wr_en) begin
            case (a_dec)
                A_OWN_SET: st_d.own  = st_q.own  |  wdata;
                A_OWN_CLR: st_d.own  = st_q.own  & ~wdata;
                A_OE_SET:  st_d.oe   = st_q.oe   |  wdata;
                A_OE_CLR:  st_d.oe   = st_q.oe   & ~wdata;
                A_PU_SET:  st_d.pu   = st_q.pu   |  wdata;
                A_PU_CLR:  st_d.pu   = st_q.pu   & ~wdata;
                A_FLT_SET: st_d.flt  = st_q.flt  |  wdata;
                A_FLT_CLR: st_d.flt  = st_q.flt  & ~wdata;
                A_IEN_SET: st_d.ien  = st_q.ien  |  wdata;
                A_IEN_CLR: st_d.ien  = st_q.ien  & ~wdata;
                A_DO_SET:  st_d.dout = st_q.dout |  wdata;
                A_DO_CLR:  st_d.dout = st_q.dout & ~wdata;
                A_SEL_A:   st_d.sel  = st_q.sel  & ~wdata;
                A_SEL_B:   st_d.sel  = st_q.sel  |  wdata;
                default: ;
            endcase
        end
        // read-to-clear, but a change arriving in the same cycle survives
        st_d.evt = ((rd_en && a_dec == A_EVT_STAT) ? '0 : st_q.evt) | pin_change;

        rdata = '0;
        if (rd_en) begin
            case (a_dec)
                A_OWN_STAT: rdata = st_q.own;
                A_OE_STAT:  rdata = st_q.oe;
                A_PU_STAT:  rdata = st_q.pu;
                A_FLT_STAT: rdata = st_q.flt;
                A_IEN_STAT: rdata = st_q.ien;
                A_DO_STAT:  rdata = st_q.dout;
                A_SEL_STAT: rdata = st_q.sel;
                A_PIN_STAT: rdata = pin_lvl;
                A_EVT_STAT: rdata = st_q.evt;
                default:    rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_ST;
        else        st_q <= st_d;
    end

    assign pin_pu = st_q.pu;
    assign irq    = |(st_q.evt & st_q.ien);

endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk
    import gpio_port_pkg::*;
#(
    parameter int N = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [N-1:0]      wdata,
    input logic [N-1:0]      own,
    input logic [N-1:0]      oe,
    input logic [N-1:0]      sel,
    input logic [N-1:0]      ien,
    input logic [N-1:0]      evt,
    input logic [N-1:0]      lvl,
    input logic [N-1:0]      pin_out,
    input logic [N-1:0]      pin_oe,
    input logic [N-1:0]      pa_out,
    input logic              irq
);

    assert_oe_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_OE_SET) |=>
            ((oe & $past(wdata)) == $past(wdata)) &&
            ((oe & ~$past(wdata)) == ($past(oe) & ~$past(wdata))));

    assert_oe_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_OE_CLR) |=>
            ((oe & $past(wdata)) == '0) &&
            ((oe & ~$past(wdata)) == ($past(oe) & ~$past(wdata))));

    assert_own_route_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & own) == (oe & own));

    assert_pa_route_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~own & ~sel) == (pa_out & ~own & ~sel));

    assert_change_latched_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl != $past(lvl)) |->
            ((evt & (lvl ^ $past(lvl))) == (lvl ^ $past(lvl))));

    assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == '0) |-> !irq);

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_EVT_STAT) |=> (evt == (lvl ^ $past(lvl))));

endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.N(N)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .own     (st_q.own),
    .oe      (st_q.oe),
    .sel     (st_q.sel),
    .ien     (st_q.ien),
    .evt     (st_q.evt),
    .lvl     (pin_lvl),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .pa_out  (pa_out),
    .irq     (irq)
);

// File: tb/gpio_port_ctrl_tb.sv
module gpio_port_ctrl_tb_top;

    localparam int N = 32;
    localparam int FLT_DIV = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [4:0]   addr = '0;
    logic [N-1:0] wdata = '0;
    logic [N-1:0] rdata;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] pin_out, pin_oe, pin_pu;
    logic [N-1:0] pa_out = '0, pa_oe = '0, pb_out = '0, pb_oe = '0;
    logic         irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [N-1:0] m_own, m_oe, m_pu, m_ien, m_dout, m_sel, m_evt, m_pin;

    always #2.5 clk = ~clk;

    gpio_port_ctrl #(.N(N), .FLT_DIV(FLT_DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .pin_pu(pin_pu), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_out(pb_out), .pb_oe(pb_oe), .irq(irq)
    );

    task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [4:0] a, logic [N-1:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [N-1:0] v);
        rd_en = 1'b1; addr = a;
        @(negedge clk); v = rdata;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    function automatic logic [N-1:0] exp_out(logic [N-1:0] own, sel, gp, a, b);
        return (own & gp) | (~own & ~sel & a) | (~own & sel & b);
    endfunction

    task automatic check_ports(string req);
        @(negedge clk);
        check({req, " pin_out"}, pin_out, exp_out(m_own, m_sel, m_dout, pa_out, pb_out));
        check({req, " pin_oe"},  pin_oe,  exp_out(m_own, m_sel, m_oe, pa_oe, pb_oe));
        check({req, " pin_pu"},  pin_pu,  m_pu);
        check({req, " irq"},     N'(irq), N'(|(m_evt & m_ien)));
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] v;
        void'($urandom(32'h5eed_0042));
        m_own = '1; m_oe = '0; m_pu = '1; m_ien = '0;
        m_dout = '0; m_sel = '0; m_evt = '0; m_pin = '0;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(5'd2, v);  check("R1 own", v, '1);
        rd(5'd5, v);  check("R1 oe", v, '0);
        rd(5'd8, v);  check("R1 pu", v, '1);
        rd(5'd11, v); check("R1 flt", v, '0);
        rd(5'd14, v); check("R1 ien", v, '0);
        rd(5'd17, v); check("R1 dout", v, '0);
        rd(5'd20, v); check("R1 sel", v, '0);
        rd(5'd22, v); check("R1 evt", v, '0);
        check_ports("R1");

        // R5 latency: not at second edge, visible at third
        pin_in = 32'h0000_0011;
        idle(2);
        rd(5'd21, v); check("R5 early", v, '0);
        rd(5'd21, v); check("R5 level", v, 32'h0000_0011);
        m_pin = 32'h0000_0011;
        // R6 rising events latched
        rd(5'd22, v); check("R6 rise", v, 32'h0000_0011);
        // R6 falling edge
        pin_in = 32'h0000_0001;
        idle(4);
        rd(5'd22, v); check("R6 fall", v, 32'h0000_0010);
        m_pin = 32'h0000_0001;

        // R7 masked event keeps latched, irq low; unmask raises irq
        pin_in = 32'h0000_0101;
        idle(4);
        m_pin = pin_in;
        @(negedge clk); check("R7 masked irq", N'(irq), '0); @(posedge clk); #1;
        wr(5'd12, 32'h0000_0100);
        @(negedge clk); check("R7 unmasked irq", N'(irq), N'(1)); @(posedge clk); #1;
        wr(5'd13, '1);

        // R8 change in the same cycle as the read stays latched
        rd(5'd22, v); check("R8 clear", v, 32'h0000_0100);
        rd(5'd22, v); check("R8 empty", v, '0);
        pin_in = 32'h0000_0001;
        idle(2);
        rd(5'd22, v); check("R8 read before latch", v, '0);
        rd(5'd22, v); check("R8 same-cycle kept", v, 32'h0000_0100);
        m_pin = pin_in;

        // R9 glitch filter on pin 5
        wr(5'd9, 32'h0000_0020);
        idle(10);
        rd(5'd22, v);
        pin_in[5] = 1'b1; idle(1); pin_in[5] = 1'b0;
        idle(20);
        rd(5'd21, v); check("R9 glitch level", v, 32'h0000_0001);
        rd(5'd22, v); check("R9 glitch event", v, '0);
        pin_in[5] = 1'b1;
        idle(3 * FLT_DIV + 3);
        rd(5'd21, v); check("R9 stable level", v, 32'h0000_0021);
        rd(5'd22, v); check("R9 stable event", v, 32'h0000_0020);
        wr(5'd10, 32'h0000_0020);
        m_pin = pin_in;
        idle(10);
        rd(5'd22, v);

        // R4 peripheral B routing and R10 pull-up on peripheral pins
        pa_out = 32'hAAAA_0000; pa_oe = 32'h0F0F_0000;
        pb_out = 32'h5555_0000; pb_oe = 32'hF0F0_0000;
        wr(5'd1, 32'hFFFF_0000); m_own = 32'h0000_FFFF;
        wr(5'd19, 32'hFF00_0000); m_sel = 32'hFF00_0000;
        wr(5'd7, 32'h00FF_0000); m_pu = 32'hFF00_FFFF;
        check_ports("R4 R10 periph");
        rd(5'd20, v); check("R4 sel", v, 32'hFF00_0000);
        wr(5'd18, 32'h0F00_0000); m_sel = 32'hF000_0000;
        check_ports("R4 sel A");

        // R3 output latch
        wr(5'd3, 32'h0000_FFFF); m_oe = 32'h0000_FFFF;
        wr(5'd15, 32'h0000_1234); m_dout = 32'h0000_1234;
        wr(5'd16, 32'h0000_0204); m_dout = 32'h0000_1030;
        rd(5'd17, v); check("R3 dout", v, 32'h0000_1030);
        check_ports("R3");

        // constrained random: R2 R3 R4 R6 R7 R8 R10
        for (int it = 0; it < 300; it++) begin
            logic [N-1:0] msk;
            int op;
            msk = $urandom();
            op = $urandom_range(0, 7);
            pa_out = $urandom(); pa_oe = $urandom();
            pb_out = $urandom(); pb_oe = $urandom();
            case (op)
                0: if ($urandom_range(0, 1) == 1) begin wr(5'd0, msk); m_own |= msk; end
                   else begin wr(5'd1, msk); m_own &= ~msk; end
                1: if ($urandom_range(0, 1) == 1) begin wr(5'd3, msk); m_oe |= msk; end
                   else begin wr(5'd4, msk); m_oe &= ~msk; end
                2: if ($urandom_range(0, 1) == 1) begin wr(5'd6, msk); m_pu |= msk; end
                   else begin wr(5'd7, msk); m_pu &= ~msk; end
                3: if ($urandom_range(0, 1) == 1) begin wr(5'd12, msk); m_ien |= msk; end
                   else begin wr(5'd13, msk); m_ien &= ~msk; end
                4: if ($urandom_range(0, 1) == 1) begin wr(5'd15, msk); m_dout |= msk; end
                   else begin wr(5'd16, msk); m_dout &= ~msk; end
                5: if ($urandom_range(0, 1) == 1) begin wr(5'd19, msk); m_sel |= msk; end
                   else begin wr(5'd18, msk); m_sel &= ~msk; end
                6: begin
                    pin_in = msk;
                    idle(3);
                    m_evt |= m_pin ^ msk;
                    m_pin = msk;
                    rd(5'd21, v); check("R5 random level", v, m_pin);
                end
                default: begin
                    rd(5'd22, v); check("R8 random evt", v, m_evt);
                    m_evt = '0;
                end
            endcase
            check_ports("R2 R4 R7 R10 random");
            case (op)
                0: begin rd(5'd2, v);  check("R2 own", v, m_own); end
                1: begin rd(5'd5, v);  check("R2 oe", v, m_oe); end
                2: begin rd(5'd8, v);  check("R2 pu", v, m_pu); end
                3: begin rd(5'd14, v); check("R2 ien", v, m_ien); end
                4: begin rd(5'd17, v); check("R3 dout", v, m_dout); end
                5: begin rd(5'd20, v); check("R4 sel", v, m_sel); end
                default: ;
            endcase
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule